// File: doc/BRIEF.md
# Vertical sub-band luma reconstructor

This block rebuilds full-height luminance from two vertical sub-bands that arrive side by side. The low-pass main band and the high-pass helper band each arrive as one 8-bit pixel per cycle. Both streams are written into line memories. While interpolation is enabled, every output pixel is a weighted sum of seven vertically aligned samples. Four of them come from the main band: the current line and the three lines before it. Three come from the helper band: the current line and the two lines before it. Before the helper samples enter the sum, their mid-level offset is removed.

The weights are chosen by a line phase that steps through four values, once per line. A second weight set is used in film mode in place of the camera-mode set. The weights come from a table parameter, indexed by mode, phase and tap. Each weight is signed fixed point with 8 fractional bits. The sum is rounded and then clipped to the active luma range. With interpolation disabled, the main luma is passed through unchanged. Outside valid samples the output holds the blanking level.

Top module: `vr_luma_recon`

## Requirements
- R1: While reset is asserted, y_vld_o is 0 and y_o is 16.
- R2: Each input sample with pix_vld_i=1 produces exactly one output sample with y_vld_o=1 on the next clock. A cycle with pix_vld_i=0 gives y_vld_o=0 on the next clock.
- R3: Whenever y_vld_o is 0, y_o is the blanking code 16.
- R4: With interp_i=0, y_o equals the main_i value sampled one cycle earlier, over the full range 0 to 255.
- R5: With interp_i=1 and the warm-up over, the output is the weighted sum over taps 0..6. Taps 0..3 are the main samples at the same pixel position in the current line and in the lines 1, 2 and 3 back. Taps 4..6 are the helper samples at that position in the current line and in the lines 1 and 2 back, each minus 128.
- R6: The line phase is the line index since the last sof_i, taken modulo 4. A line starts with sol_i or sof_i together with its first valid pixel. sof_i sets the index to 0. The phase selects the weight row.
- R7: film_i=0 selects table entry [0], the camera set. film_i=1 selects table entry [1], the film set.
- R8: Rounding is half-up: the sum gets 128 added and is then shifted arithmetically right by 8.
- R9: In interpolation mode the rounded result is clipped to the range 16 to 191.
- R10: In interpolation mode the first three lines after sof_i (indices 0, 1, 2) output the code 16 with y_vld_o=1.
- R11: The line memories and the line index keep advancing in bypass mode. A switch to interpolation in the middle of a field therefore uses the history stored during bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | Input sample valid |
| sol_i | input | 1 | First pixel of a line (with pix_vld_i) |
| sof_i | input | 1 | First pixel of a field (implies line start) |
| interp_i | input | 1 | 1: reconstruct, 0: bypass main band |
| film_i | input | 1 | 0: camera weights, 1: film weights |
| main_i | input | 8 | Main-band luma, straight binary |
| help_i | input | 8 | Helper-band luma, centred at 128 |
| y_vld_o | output | 1 | Output sample valid |
| y_o | output | 8 | Reconstructed luma |

## Verification
The bench targets the phase sequence across field restarts. If sof_i failed to clear the phase, film and camera rows would be paired with the wrong lines and nearly every sum would differ. Full-scale and zero inputs drive the sum past both clip limits: an unclipped design would wrap to codes above 191 or below 16, and a truncating design would miss by one on ties. A mid-line pause in pix_vld_i checks that the pixel address holds. A switch from bypass to interpolation inside a field checks that history kept during bypass is used. A design that froze its memories in bypass would mix in stale lines from an earlier field.

// File: rtl/vr_pkg.sv
package vr_pkg;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 12;
  localparam int FRAC_W   = 8;
  localparam int N_MAIN   = 4;
  localparam int N_HELP   = 3;
  localparam int N_TAP    = N_MAIN + N_HELP;
  localparam int N_PHASE  = 4;
  localparam int PH_W     = $clog2(N_PHASE);
  localparam int SMP_W    = PIX_W + 1;
  localparam int ACC_W    = COEF_W + SMP_W + $clog2(N_TAP);
  localparam int BLANK    = 16;
  localparam int ACT_MAX  = 191;
  localparam int HELP_MID = 128;
  localparam int WARM_LN  = N_MAIN - 1;

  typedef logic signed [COEF_W-1:0] coef_tab_t [2][N_PHASE][N_TAP];

  // [mode][phase][tap]: taps 0..3 main (newest first), 4..6 helper
  localparam coef_tab_t DEF_COEF = '{
    '{ '{12'sd32, 12'sd192, 12'sd32,  12'sd0,  -12'sd24, 12'sd48,  -12'sd24},
       '{12'sd0,  12'sd128, 12'sd128, 12'sd0,   12'sd0,  -12'sd64,  12'sd64},
       '{12'sd0,  12'sd32,  12'sd192, 12'sd32, -12'sd16, 12'sd32,  -12'sd16},
       '{12'sd16, 12'sd112, 12'sd112, 12'sd16,  12'sd40, -12'sd80,  12'sd40} },
    '{ '{12'sd0,  12'sd256, 12'sd0,   12'sd0,   12'sd0,   12'sd0,   12'sd0},
       '{12'sd64, 12'sd128, 12'sd64,  12'sd0,  -12'sd32, 12'sd64,  -12'sd32},
       '{12'sd0,  12'sd128, 12'sd128, 12'sd0,   12'sd48, -12'sd48,  12'sd0},
       '{12'sd0,  12'sd64,  12'sd128, 12'sd64, -12'sd20, 12'sd40,  -12'sd20} }
  };
endpackage

// File: rtl/vr_line_store.sv
module vr_line_store #(
  parameter int W   = 8,
  parameter int N   = 4,
  parameter int LEN = 16,
  localparam int AW = $clog2(LEN)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  tap_o [N]
);
  logic [W-1:0] mem [N-1][LEN];

  // column-wise shift: each write pushes the column one line deeper
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[0][addr_i] <= din_i;
      for (int k = 1; k < N-1; k++) mem[k][addr_i] <= mem[k-1][addr_i];
    end
  end

  assign tap_o[0] = din_i;
  for (genvar k = 1; k < N; k++) begin : g_tap
    assign tap_o[k] = mem[k-1][addr_i];
  end
endmodule

// File: rtl/vr_seq.sv
module vr_seq
  import vr_pkg::*;
#(
  parameter int LINE_LEN = 16,
  localparam int AW = $clog2(LINE_LEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pix_vld_i,
  input  logic            sol_i,
  input  logic            sof_i,
  output logic [AW-1:0]   addr_o,
  output logic [PH_W-1:0] phase_o,
  output logic            warm_o
);
  localparam int SW = $clog2(WARM_LN + 1);

  logic [AW-1:0]   x_q;
  logic [PH_W-1:0] ph_q;
  logic [SW-1:0]   seen_q, seen_d;
  logic            new_ln;

  assign new_ln = sol_i | sof_i;
  assign addr_o = new_ln ? '0 : x_q;

  always_comb begin
    phase_o = ph_q;
    seen_d  = seen_q;
    if (sof_i) begin
      phase_o = '0;
      seen_d  = '0;
    end else if (sol_i) begin
      phase_o = ph_q + 1'b1;
      if (seen_q != SW'(WARM_LN)) seen_d = seen_q + 1'b1;
    end
  end

  assign warm_o = (seen_d == SW'(WARM_LN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      ph_q   <= '0;
      seen_q <= '0;
    end else if (pix_vld_i) begin
      x_q    <= (addr_o == AW'(LINE_LEN-1)) ? '0 : addr_o + 1'b1;
      ph_q   <= phase_o;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/vr_mac.sv
module vr_mac
  import vr_pkg::*;
#(
  parameter coef_tab_t COEF = DEF_COEF
) (
  input  logic [PIX_W-1:0] m_i [N_MAIN],
  input  logic [PIX_W-1:0] h_i [N_HELP],
  input  logic             film_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [PIX_W-1:0] y_o
);
  localparam logic signed [ACC_W-1:0] LO  = ACC_W'(BLANK);
  localparam logic signed [ACC_W-1:0] HI  = ACC_W'(ACT_MAX);
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W-1));

  logic signed [SMP_W-1:0] smp [N_TAP];
  logic signed [ACC_W-1:0] acc, q;

  for (genvar k = 0; k < N_MAIN; k++) begin : g_m
    assign smp[k] = $signed({1'b0, m_i[k]});
  end
  for (genvar k = 0; k < N_HELP; k++) begin : g_h
    assign smp[N_MAIN+k] = $signed({1'b0, h_i[k]}) - SMP_W'(HELP_MID);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_TAP; k++)
      acc = acc + ACC_W'(COEF[film_i][phase_i][k]) * ACC_W'(smp[k]);
    q = (acc + RND) >>> FRAC_W;
    if (q < LO)      y_o = PIX_W'(BLANK);
    else if (q > HI) y_o = PIX_W'(ACT_MAX);
    else             y_o = q[PIX_W-1:0];
  end
endmodule

// File: rtl/vr_luma_recon.sv
module vr_luma_recon
  import vr_pkg::*;
#(
  parameter int        LINE_LEN = 256,
  parameter coef_tab_t COEF     = DEF_COEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_vld_i,
  input  logic             sol_i,
  input  logic             sof_i,
  input  logic             interp_i,
  input  logic             film_i,
  input  logic [PIX_W-1:0] main_i,
  input  logic [PIX_W-1:0] help_i,
  output logic             y_vld_o,
  output logic [PIX_W-1:0] y_o
);
  localparam int AW = $clog2(LINE_LEN);

  logic [AW-1:0]    addr;
  logic [PH_W-1:0]  phase;
  logic             warm;
  logic [PIX_W-1:0] m_tap [N_MAIN];
  logic [PIX_W-1:0] h_tap [N_HELP];
  logic [PIX_W-1:0] rec_y, y_d;

  vr_seq #(.LINE_LEN(LINE_LEN)) u_seq (
    .clk_i, .rst_ni, .pix_vld_i, .sol_i, .sof_i,
    .addr_o(addr), .phase_o(phase), .warm_o(warm)
  );

  vr_line_store #(.W(PIX_W), .N(N_MAIN), .LEN(LINE_LEN)) u_main (
    .clk_i, .we_i(pix_vld_i), .addr_i(addr), .din_i(main_i), .tap_o(m_tap)
  );

  vr_line_store #(.W(PIX_W), .N(N_HELP), .LEN(LINE_LEN)) u_help (
    .clk_i, .we_i(pix_vld_i), .addr_i(addr), .din_i(help_i), .tap_o(h_tap)
  );

  vr_mac #(.COEF(COEF)) u_mac (
    .m_i(m_tap), .h_i(h_tap), .film_i, .phase_i(phase), .y_o(rec_y)
  );

  always_comb begin
    if (!pix_vld_i)     y_d = PIX_W'(BLANK);
    else if (!interp_i) y_d = main_i;
    else if (!warm)     y_d = PIX_W'(BLANK);
    else                y_d = rec_y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_vld_o <= 1'b0;
      y_o     <= PIX_W'(BLANK);
    end else begin
      y_vld_o <= pix_vld_i;
      y_o     <= y_d;
    end
  end
endmodule

// File: rtl/vr_luma_recon_chk.sv
module vr_luma_recon_chk
  import vr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_vld_i,
  input logic             sof_i,
  input logic             interp_i,
  input logic [PIX_W-1:0] main_i,
  input logic             y_vld_o,
  input logic [PIX_W-1:0] y_o
);
  assert_vld_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_i |=> y_vld_o);
  assert_idle_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_i |=> !y_vld_o);
  assert_blank_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_vld_o |-> y_o == PIX_W'(BLANK));
  assert_bypass_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && !interp_i) |=> y_o == $past(main_i));
  assert_clip_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && interp_i) |=> (y_o >= PIX_W'(BLANK) && y_o <= PIX_W'(ACT_MAX)));
  assert_warmup_blank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && interp_i && sof_i) |=> y_o == PIX_W'(BLANK));
endmodule

bind vr_luma_recon vr_luma_recon_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_vld_i(pix_vld_i), .sof_i(sof_i),
  .interp_i(interp_i), .main_i(main_i), .y_vld_o(y_vld_o), .y_o(y_o)
);

// File: tb/sim_vr_luma_recon.sv
module sim_vr_luma_recon;
  localparam int LL = 8;
  localparam vr_pkg::coef_tab_t CT = '{
    '{ '{12'sd40, 12'sd176, 12'sd40,  12'sd0,  -12'sd30, 12'sd60,  -12'sd20},
       '{12'sd0,  12'sd128, 12'sd128, 12'sd0,   12'sd10, -12'sd70,  12'sd64},
       '{-12'sd8, 12'sd40,  12'sd192, 12'sd32, -12'sd16, 12'sd36,  -12'sd16},
       '{12'sd16, 12'sd112, 12'sd100, 12'sd28,  12'sd44, -12'sd80,  12'sd40} },
    '{ '{12'sd0,  12'sd256, 12'sd0,   12'sd0,   12'sd20,  12'sd0,   12'sd0},
       '{12'sd64, 12'sd128, 12'sd64,  12'sd0,  -12'sd32, 12'sd64,  -12'sd30},
       '{12'sd0,  12'sd120, 12'sd136, 12'sd0,   12'sd48, -12'sd48,  12'sd6},
       '{12'sd4,  12'sd60,  12'sd128, 12'sd64, -12'sd20, 12'sd44,  -12'sd20} }
  };

  logic clk = 0, rst_n = 0;
  logic pix_vld = 0, sol = 0, sof = 0, interp = 0, film = 0;
  logic [7:0] main_d = 0, help_d = 0;
  logic y_vld;
  logic [7:0] y;

  int total = 0, fails = 0;
  bit done = 0, run_mon = 0;
  int exp_q[$];
  string tag_q[$];
  int mh[3][LL];
  int hh[2][LL];
  int lidx = 0, xp = 0;

  always #5 clk = ~clk;

  vr_luma_recon #(.LINE_LEN(LL), .COEF(CT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_vld_i(pix_vld), .sol_i(sol), .sof_i(sof),
    .interp_i(interp), .film_i(film), .main_i(main_d), .help_i(help_d),
    .y_vld_o(y_vld), .y_o(y)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pix(int m, int h, bit s_l, bit s_f, bit ip, bit fm);
    int mt[4];
    int ht[3];
    int acc, e;
    string t;
    if (s_f) lidx = 0; else if (s_l) lidx++;
    if (s_l || s_f) xp = 0;
    mt[0] = m; ht[0] = h - 128;
    for (int k = 1; k < 4; k++) mt[k] = mh[k-1][xp];
    for (int k = 1; k < 3; k++) ht[k] = hh[k-1][xp] - 128;
    if (!ip) begin e = m; t = "R4"; end
    else if (lidx < 3) begin e = 16; t = "R10"; end
    else begin
      acc = 0;
      for (int k = 0; k < 4; k++) acc += int'(CT[fm][lidx%4][k]) * mt[k];
      for (int k = 0; k < 3; k++) acc += int'(CT[fm][lidx%4][4+k]) * ht[k];
      e = (acc + 128) >>> 8;  // R8 half-up
      t = "R5 R6 R7 R8";
      if (e < 16) begin e = 16; t = "R9"; end
      if (e > 191) begin e = 191; t = "R9"; end
    end
    exp_q.push_back(e); tag_q.push_back(t);
    mh[2][xp] = mh[1][xp]; mh[1][xp] = mh[0][xp]; mh[0][xp] = m;
    hh[1][xp] = hh[0][xp]; hh[0][xp] = h;
    xp++;
    pix_vld = 1; sol = s_l; sof = s_f; interp = ip; film = fm;
    main_d = 8'(m); help_d = 8'(h);
    @(negedge clk);
    sol = 0; sof = 0;
  endtask

  task automatic idle(int n);
    pix_vld = 0;
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 pattern, 1 all max, 2 all zero
  task automatic line(bit first, bit ip, bit fm, int seed, int kind);
    for (int x = 0; x < LL; x++) begin
      int m, h;
      m = (kind == 1) ? 255 : (kind == 2) ? 0 : (seed*37 + x*23 + x*x*5) & 255;
      h = (kind == 1) ? 255 : (kind == 2) ? 0 : 58 + ((seed*13 + x*29) % 141);
      pix(m, h, (x == 0) && !first, first && (x == 0), ip, fm);
    end
    idle(2);
  endtask

  initial begin : monitor
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (run_mon) begin
        if (y_vld) begin
          if (exp_q.size() == 0) check("R2", 1, 0);
          else check(tag_q.pop_front(), y, exp_q.pop_front());
        end else check("R3", y, 16);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1", y_vld, 0);
    check("R1", y, 16);
    rst_n = 1;
    @(negedge clk);
    run_mon = 1;
    // camera field: R6 phases cycle over 8 lines
    for (int l = 0; l < 8; l++) line(l == 0, 1, 0, l + 1, 0);
    // film field, R7
    for (int l = 0; l < 7; l++) line(l == 0, 1, 1, 3*l + 2, 0);
    // field restart mid-sequence resets phase, R6
    for (int l = 0; l < 5; l++) line(l == 0, 1, 0, 7*l + 5, 0);
    // bypass then interp inside one field: R4, R11
    for (int l = 0; l < 3; l++) line(l == 0, 0, 0, l + 9, 0);
    for (int l = 0; l < 3; l++) line(0, 1, 1, l + 20, 0);
    // clip limits R9
    for (int l = 0; l < 5; l++) line(l == 0, 1, 0, 0, 1);
    for (int l = 0; l < 5; l++) line(l == 0, 1, 1, 0, 2);
    // pause inside a line: address must hold (R5)
    for (int l = 0; l < 4; l++) begin
      for (int x = 0; x < LL; x++) begin
        pix((x*41 + l*17) & 255, 70 + ((x*9 + l) % 120), (x == 0) && (l != 0), (x == 0) && (l == 0), 1, 0);
        if (x == 3) idle(3);
      end
      idle(1);
    end
    idle(3);
    check("R2", exp_q.size(), 0);
    run_mon = 0;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule